// File: doc/BRIEF.md
# Two-Sided Request/Response Mailbox

This block is a small bank of registers shared by a host processor and a DSP processor. The host always opens an exchange. It loads up to two 16-bit parameter words and then writes a command word. That one write stores a 4-bit command code and raises a request-valid flag. The DSP sees the request through its pending output, reads the registers and acknowledges by clearing the flag. It answers by writing a response data word and a status word, and the status word raises a response-valid flag that only the host may clear.

Hardware enforces who owns each flag. Only the producer of a direction can set its valid flag. Only the consumer can clear it. A write from the wrong side to a flag or to a register it does not own changes nothing. No software lock is needed to keep the two sides coherent.

Both sides have an identical register port with a write strobe, a read strobe, a 3-bit address and 16-bit data. Read data is registered and holds its value between reads.

Top module: `mailbox_flags`

## Requirements
- R1: While `rst_n` is low, every register and both valid flags are zero, `req_pend` and `rsp_pend` are low, and both read data outputs are zero.
- R2: A host write to address 0 stores `wdata[3:0]` as the command code. If `wdata[5]` is 1, the same write sets the request-valid flag. Address 0 reads as {10'b0, request-valid at bit 5, 1'b0, command at [3:0]}. `req_pend` equals the request-valid flag from the cycle after the write.
- R3: A host write to address 0 with `wdata[5]` = 0 updates the command code and leaves the request-valid flag unchanged. The host has no way to clear that flag.
- R4: A DSP write to address 0 with `wdata[5]` = 1 clears the request-valid flag. DSP writes to address 0 never change the command code, and with `wdata[5]` = 0 they have no effect.
- R5: Addresses 1 and 2 are 16-bit parameter registers. Only the host can write them, and DSP writes to them are ignored.
- R6: A DSP write to address 3 stores `wdata[3:0]` as the status code. If `wdata[5]` is 1, the same write sets the response-valid flag; with `wdata[5]` = 0 the flag is unchanged. Address 3 reads with the same layout as address 0. `rsp_pend` equals the response-valid flag.
- R7: A host write to address 3 with `wdata[5]` = 1 clears the response-valid flag. Host writes never change the status code.
- R8: Address 4 is a 16-bit response data register. Only the DSP can write it, and host writes are ignored.
- R9: If the producer sets a flag and the consumer clears it in the same cycle, the set wins and the flag is 1 afterwards.
- R10: A read strobe loads the addressed value into that side's read data on the next clock edge. The value is the one held before any write in the same cycle. Addresses 5 to 7 read as zero. Read data holds its value while no read strobe is given, and both sides see the same image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 3 | Host register address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| d_wr | input | 1 | DSP write strobe |
| d_rd | input | 1 | DSP read strobe |
| d_addr | input | 3 | DSP register address |
| d_wdata | input | 16 | DSP write data |
| d_rdata | output | 16 | DSP read data, registered |
| req_pend | output | 1 | Request pending, toward the DSP |
| rsp_pend | output | 1 | Response pending, toward the host |

## Verification
Every result is due exactly one clock edge after its stimulus. Flag changes appear on `req_pend` and `rsp_pend` after the edge that takes the write. Read data appears after the edge that takes the read strobe and shows the state from before that edge. The bench applies a stimulus each cycle and advances a behavioural model by one step. At the next falling edge it compares all four outputs against the model, so each result is sampled in the first cycle it is due. Directed steps cover each owner rule and the same-cycle set/clear cases, and a long random phase follows them.

// File: rtl/mailbox_flags.sv
module mailbox_flags #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int AW = 3,
  parameter int VB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          d_wr,
  input  logic          d_rd,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  output logic [DW-1:0] d_rdata,
  output logic          req_pend,
  output logic          rsp_pend
);
  localparam int NSLOT = 2 ** AW;
  localparam int NREG  = 5;
  localparam logic [AW-1:0] A_CMD = AW'(0);
  localparam logic [AW-1:0] A_P0  = AW'(1);
  localparam logic [AW-1:0] A_P1  = AW'(2);
  localparam logic [AW-1:0] A_STS = AW'(3);
  localparam logic [AW-1:0] A_RD  = AW'(4);

  logic [CW-1:0] cmd_q, sts_q;
  logic          req_v, rsp_v;
  logic [DW-1:0] par0_q, par1_q, resp_q;
  logic [DW-1:0] img [NSLOT];

  wire h_cmd_wr = h_wr && h_addr == A_CMD;
  wire h_sts_wr = h_wr && h_addr == A_STS;
  wire d_cmd_wr = d_wr && d_addr == A_CMD;
  wire d_sts_wr = d_wr && d_addr == A_STS;

  wire req_set = h_cmd_wr && h_wdata[VB];
  wire req_clr = d_cmd_wr && d_wdata[VB];
  wire rsp_set = d_sts_wr && d_wdata[VB];
  wire rsp_clr = h_sts_wr && h_wdata[VB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sts_q  <= '0;
      req_v  <= 1'b0;
      rsp_v  <= 1'b0;
      par0_q <= '0;
      par1_q <= '0;
      resp_q <= '0;
    end else begin
      if (h_cmd_wr) cmd_q <= h_wdata[CW-1:0];
      if (d_sts_wr) sts_q <= d_wdata[CW-1:0];
      if (req_set) req_v <= 1'b1;
      else if (req_clr) req_v <= 1'b0;
      if (rsp_set) rsp_v <= 1'b1;
      else if (rsp_clr) rsp_v <= 1'b0;
      if (h_wr && h_addr == A_P0) par0_q <= h_wdata;
      if (h_wr && h_addr == A_P1) par1_q <= h_wdata;
      if (d_wr && d_addr == A_RD) resp_q <= d_wdata;
    end
  end

  assign img[0] = {{(DW-VB-1){1'b0}}, req_v, {(VB-CW){1'b0}}, cmd_q};
  assign img[1] = par0_q;
  assign img[2] = par1_q;
  assign img[3] = {{(DW-VB-1){1'b0}}, rsp_v, {(VB-CW){1'b0}}, sts_q};
  assign img[4] = resp_q;

  for (genvar s = NREG; s < NSLOT; s++) begin : g_hole
    assign img[s] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
      d_rdata <= '0;
    end else begin
      if (h_rd) h_rdata <= img[h_addr];
      if (d_rd) d_rdata <= img[d_addr];
    end
  end

  assign req_pend = req_v;
  assign rsp_pend = rsp_v;
endmodule

module mailbox_flags_chk #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int VB = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_wdata,
  input logic          d_wr,
  input logic [AW-1:0] d_addr,
  input logic [DW-1:0] d_wdata,
  input logic          req_pend,
  input logic          rsp_pend
);
  wire hs_req = h_wr && h_addr == AW'(0) && h_wdata[VB];
  wire dc_req = d_wr && d_addr == AW'(0) && d_wdata[VB];
  wire ds_rsp = d_wr && d_addr == AW'(3) && d_wdata[VB];
  wire hc_rsp = h_wr && h_addr == AW'(3) && h_wdata[VB];

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !req_pend && !rsp_pend);
  p_req_set_r2: assert property (@(posedge clk) disable iff (!rst_n) hs_req |=> req_pend);
  p_req_only_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_pend && !hs_req |=> !req_pend);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pend && !dc_req |=> req_pend);
  p_req_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dc_req && !hs_req |=> !req_pend);
  p_rsp_set_r6: assert property (@(posedge clk) disable iff (!rst_n) ds_rsp |=> rsp_pend);
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pend && !hc_rsp |=> rsp_pend);
  p_rsp_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hc_rsp && !ds_rsp |=> !rsp_pend);
  p_rsp_only_dsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_pend && !ds_rsp |=> !rsp_pend);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req && dc_req |=> req_pend);
endmodule

bind mailbox_flags mailbox_flags_chk #(.DW(DW), .AW(AW), .VB(VB)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
  .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata),
  .req_pend(req_pend), .rsp_pend(rsp_pend)
);

// File: tb/mailbox_flags_tb_top.sv
`timescale 1ns/1ps
module mailbox_flags_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, d_wr = 0, d_rd = 0;
  logic [2:0] h_addr = 0, d_addr = 0;
  logic [15:0] h_wdata = 0, d_wdata = 0, h_rdata, d_rdata;
  logic req_pend, rsp_pend;

  always #2 clk = ~clk;

  mailbox_flags dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_wr(d_wr), .d_rd(d_rd), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .req_pend(req_pend), .rsp_pend(rsp_pend)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cmd = 0, m_sts = 0, m_rv = 0, m_sv = 0, m_p0 = 0, m_p1 = 0, m_rsp = 0;
  int e_hr = 0, e_dr = 0;
  string ptag = "R1";

  function automatic int view(int a);
    case (a)
      0: return (m_rv << 5) | m_cmd;
      1: return m_p0;
      2: return m_p1;
      3: return (m_sv << 5) | m_sts;
      4: return m_rsp;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(ptag, "h_rdata", int'(h_rdata), e_hr);
    chk(ptag, "d_rdata", int'(d_rdata), e_dr);
    chk(ptag, "req_pend", int'(req_pend), m_rv);
    chk(ptag, "rsp_pend", int'(rsp_pend), m_sv);
  endtask

  task automatic cyc(bit hw, bit hr, int ha, int hd, bit dw, bit dr, int da, int dd, string tag);
    bit rs, rc, ss, sc;
    @(negedge clk);
    compare();
    h_wr = hw; h_rd = hr; h_addr = 3'(ha); h_wdata = 16'(hd);
    d_wr = dw; d_rd = dr; d_addr = 3'(da); d_wdata = 16'(dd);
    if (hr) e_hr = view(ha & 7);
    if (dr) e_dr = view(da & 7);
    rs = hw && (ha & 7) == 0 && hd[5];
    rc = dw && (da & 7) == 0 && dd[5];
    ss = dw && (da & 7) == 3 && dd[5];
    sc = hw && (ha & 7) == 3 && hd[5];
    if (hw && (ha & 7) == 0) m_cmd = hd & 15;
    if (hw && (ha & 7) == 1) m_p0 = hd & 16'hffff;
    if (hw && (ha & 7) == 2) m_p1 = hd & 16'hffff;
    if (dw && (da & 7) == 3) m_sts = dd & 15;
    if (dw && (da & 7) == 4) m_rsp = dd & 16'hffff;
    m_rv = rs ? 1 : (rc ? 0 : m_rv);
    m_sv = ss ? 1 : (sc ? 0 : m_sv);
    ptag = tag;
  endtask

  task automatic hwr(int a, int d, string t); cyc(1, 0, a, d, 0, 0, 0, 0, t); endtask
  task automatic dwr(int a, int d, string t); cyc(0, 0, 0, 0, 1, 0, a, d, t); endtask
  task automatic rd2(int a, string t); cyc(0, 1, a, 0, 0, 1, a, 0, t); endtask
  task automatic idle(string t); cyc(0, 0, 0, 0, 0, 0, 0, 0, t); endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd2(a, "R1");
    hwr(1, 16'h0020, "R5"); hwr(2, 16'h55AA, "R5");
    hwr(0, 16'h0023, "R2"); rd2(0, "R2");
    hwr(0, 16'h0005, "R3"); rd2(0, "R3"); idle("R3");
    dwr(0, 16'h000F, "R4"); rd2(0, "R4");
    dwr(0, 16'h0020, "R4"); rd2(0, "R4");
    dwr(1, 16'hFFFF, "R5"); dwr(2, 16'h1234, "R5"); rd2(1, "R5"); rd2(2, "R5");
    dwr(3, 16'h0027, "R6"); rd2(3, "R6");
    dwr(3, 16'h0001, "R6"); rd2(3, "R6");
    hwr(3, 16'h000F, "R7"); rd2(3, "R7");
    hwr(3, 16'h0020, "R7"); rd2(3, "R7");
    dwr(4, 16'hBEEF, "R8"); hwr(4, 16'h0BAD, "R8"); rd2(4, "R8");
    hwr(0, 16'h0021, "R9");
    cyc(1, 0, 0, 16'h0026, 1, 0, 0, 16'h0020, "R9"); rd2(0, "R9");
    dwr(3, 16'h0022, "R9");
    cyc(1, 0, 3, 16'h0020, 1, 0, 3, 16'h0024, "R9"); rd2(3, "R9");
    cyc(1, 1, 0, 16'h0027, 0, 1, 0, 0, "R10"); idle("R10"); idle("R10");
    rd2(5, "R10"); rd2(6, "R10"); rd2(7, "R10");
    for (int i = 0; i < 3000; i++) begin
      int hd = $urandom, dd = $urandom;
      cyc(1'($urandom), 1'($urandom), $urandom % 8, hd,
          1'($urandom), 1'($urandom), $urandom % 8, dd, "R10");
    end
    idle("R10");
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule